// File: doc/BRIEF.md
# Receive Buffer with Fill-Level Interrupt

This block sits between a serial receiver and the CPU side of a UART. It stores incoming characters in a first-in first-out buffer of 16 entries. It compares the number of stored characters against a level picked by a 2-bit trigger select. From that comparison it raises a receive-data-available interrupt and the matching interrupt-status code. It also keeps a data-ready flag that is high whenever at least one character is waiting.

The interrupt is level-based. It stays high as long as the fill is at or above the trigger and drops as soon as a read takes the fill below it. When the buffer is switched off, the block behaves as a one-character holding register, and the interrupt then follows data-ready. When the buffer is on and every interrupt-enable bit is zero, the block runs in polled mode: the CPU watches data-ready and reads characters, and no interrupt is raised.

All outputs are registered. A write or a read strobe shows its effect on data-ready, the interrupt, the status code and the overrun flag right after the clock edge that samples it. Read data appears after the same edge as the strobe.

Top module: `rx_fifo_irq`

## Requirements
- R1: Characters are read out in the order they were written. `rd_data` carries the oldest stored character after the clock edge that samples `rd_en`.
- R2: `data_ready` goes to 1 at the edge that stores the first character and returns to 0 at the edge of the read that empties the buffer.
- R3: The trigger select picks a level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters. With the buffer on and `irq_en[0]`=1, `irq` rises and `irq_status` reads 4'b0100 at the edge where the fill reaches that level.
- R4: At the edge where a read takes the fill below the level, `irq` falls and `irq_status` returns to 4'b0001, the code for no pending interrupt.
- R5: With `irq_en[0]`=0, `irq` stays 0 and `irq_status` stays 4'b0001 whatever the fill, while `data_ready` still works.
- R6: Polled mode (buffer on, `irq_en` all zero) keeps `irq` at 0, and storage, ordering and `data_ready` work as usual.
- R7: A write that finds the buffer full is dropped, and `overrun` is set at that edge. Any later `rd_en` clears `overrun`. The dropped character never appears on `rd_data`.
- R8: With `fifo_en`=0 the buffer holds a single character. A second write before a read is dropped and sets `overrun`. `irq` equals `data_ready` when `irq_en[0]`=1, whatever the trigger select.
- R9: A change of `fifo_en` empties the buffer at the next edge: `data_ready` and `irq` go to 0, and a write in that cycle is dropped.
- R10: After reset, `data_ready`, `irq`, `overrun` and `rd_data` are 0 and `irq_status` is 4'b0001.
- R11: A read strobe while the buffer is empty leaves `rd_data` unchanged and does not disturb later storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: 16-entry buffer, 0: single holding register |
| irq_en | input | 4 | Interrupt enables; bit 0 enables the receive interrupt, bits 3..1 belong to other sources |
| trig_sel | input | 2 | Trigger level select (1, 4, 8, 14 characters) |
| wr_en | input | 1 | Character strobe from the receiver |
| wr_data | input | 8 | Received character |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 8 | Character read out |
| data_ready | output | 1 | At least one character stored |
| overrun | output | 1 | A character was dropped because the buffer was full |
| irq | output | 1 | Receive-data-available interrupt |
| irq_status | output | 4 | Interrupt-status code: 4'b0100 receive data available, 4'b0001 nothing pending |

## Verification
The hardest state to reach is the top trigger level and the full buffer. The 14-character threshold and the dropped 17th write need the buffer loaded to its limit without reads in between. The stimulus fills it one character per strobe. It checks the interrupt just below the level, at the level and one read after it. Then it writes past 16 and drains every entry to show the dropped character is absent. Switching `fifo_en` while characters are stored is the other rare case, and a dedicated scenario covers it.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

  typedef enum logic [3:0] {
    IRQ_CODE_NONE = 4'b0001,
    IRQ_CODE_RDA  = 4'b0100
  } irq_code_t;

  localparam int TRIG_LVL_0 = 1;
  localparam int TRIG_LVL_1 = 4;
  localparam int TRIG_LVL_2 = 8;
  localparam int TRIG_LVL_3 = 14;

  function automatic int trig_chars(input logic [1:0] sel);
    case (sel)
      2'b00:   return TRIG_LVL_0;
      2'b01:   return TRIG_LVL_1;
      2'b10:   return TRIG_LVL_2;
      default: return TRIG_LVL_3;
    endcase
  endfunction

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next,
  output logic              overrun
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              fifo_en_q;
  logic              flush, full, empty, wr_fire, rd_fire;
  logic [CNT_W-1:0]  cap;

  assign flush   = fifo_en ^ fifo_en_q;
  assign cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full    = count >= cap;
  assign empty   = count == '0;
  assign wr_fire = wr_en && !full && !flush;
  assign rd_fire = rd_en && !empty && !flush;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    if (flush) count_next = '0;
    else       count_next = count + CNT_W'(wr_fire) - CNT_W'(rd_fire);
  end

  // storage: plain write port, no reset, so it can map to block RAM
  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (rd_fire) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en_q <= fifo_en;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      overrun   <= 1'b0;
    end else begin
      fifo_en_q <= fifo_en;
      count     <= count_next;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (wr_fire) wr_ptr <= ptr_inc(wr_ptr);
        if (rd_fire) rd_ptr <= ptr_inc(rd_ptr);
      end
      if (wr_en && full && !flush) overrun <= 1'b1;
      else if (rd_en)              overrun <= 1'b0;
    end
  end

  // R7: occupancy never passes the physical depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R8: with the buffer off for two samples, at most one character is held
  a_r8_single_entry: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && $past(!fifo_en)) |-> (count <= CNT_W'(1)));

endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [3:0]       irq_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_next,
  output logic             data_ready,
  output logic             irq,
  output logic [3:0]       irq_status
);

  logic [CNT_W-1:0] lvl;
  logic             polled, rda, pend;

  assign lvl    = CNT_W'(trig_chars(trig_sel));
  assign polled = fifo_en && (irq_en == 4'b0000);
  assign rda    = fifo_en ? (count_next >= lvl) : (count_next != '0);
  assign pend   = irq_en[0] && !polled && rda;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_ready <= 1'b0;
      irq        <= 1'b0;
      irq_status <= IRQ_CODE_NONE;
    end else begin
      data_ready <= count_next != '0;
      irq        <= pend;
      irq_status <= pend ? IRQ_CODE_RDA : IRQ_CODE_NONE;
    end
  end

  // R2: data-ready mirrors the stored count
  a_r2_ready_tracks: assert property (@(posedge clk) disable iff (rst)
    data_ready == (count != '0));

  // R3: an interrupt in buffer mode means the fill is at the level
  a_r3_reach: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(fifo_en)) |-> (count >= $past(lvl)));

  // R4: below the level, no interrupt
  a_r4_below: assert property (@(posedge clk) disable iff (rst)
    ($past(fifo_en) && (count < $past(lvl))) |-> !irq);

  // R5: no interrupt without the receive enable
  a_r5_rx_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en[0]));

  // R6: polled mode keeps the line quiet
  a_r6_polled: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_en && (irq_en == 4'b0000)) |-> !irq);

  // R8: single-register mode, interrupt follows data-ready
  a_r8_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_en) |-> (irq == (data_ready && $past(irq_en[0]))));

endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic [3:0]        irq_en,
  input  logic [1:0]        trig_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_ready,
  output logic              overrun,
  output logic              irq,
  output logic [3:0]        irq_status
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic [CNT_W-1:0] count, count_next;

  rx_fifo_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .PTR_W  (PTR_W)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .count      (count),
    .count_next (count_next),
    .overrun    (overrun)
  );

  rx_irq_ctrl #(
    .CNT_W (CNT_W)
  ) u_irq (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .irq_en     (irq_en),
    .trig_sel   (trig_sel),
    .count      (count),
    .count_next (count_next),
    .data_ready (data_ready),
    .irq        (irq),
    .irq_status (irq_status)
  );

endmodule

// File: tb/tb_rx_fifo_irq.sv
module tb_rx_fifo_irq;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b1;
  logic [3:0] irq_en = 4'b0001;
  logic [1:0] trig_sel = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       data_ready, overrun, irq;
  logic [3:0] irq_status;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_irq #(.DATA_W(8), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .irq_en(irq_en),
    .trig_sel(trig_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun),
    .irq(irq), .irq_status(irq_status)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic drain();
    logic [7:0] d;
    for (int i = 0; i < DEPTH + 1; i++) pop(d);
  endtask

  task automatic t_reset();
    chk("R10", "data_ready", data_ready, 0);
    chk("R10", "irq", irq, 0);
    chk("R10", "overrun", overrun, 0);
    chk("R10", "rd_data", rd_data, 0);
    chk("R10", "irq_status", irq_status, 4'b0001);
  endtask

  task automatic t_order();
    logic [7:0] d;
    fifo_en = 1'b1; irq_en = 4'b0001; trig_sel = 2'b00;
    push(8'h11);
    chk("R2", "ready after first write", data_ready, 1);
    chk("R3", "irq at level 1", irq, 1);
    chk("R3", "status at level 1", irq_status, 4'b0100);
    push(8'h22); push(8'h33);
    pop(d); chk("R1", "first out", d, 8'h11);
    pop(d); chk("R1", "second out", d, 8'h22);
    chk("R2", "ready with one left", data_ready, 1);
    pop(d); chk("R1", "third out", d, 8'h33);
    chk("R2", "ready cleared when empty", data_ready, 0);
    chk("R4", "irq cleared when empty", irq, 0);
  endtask

  task automatic t_trigger(input logic [1:0] sel, input int lvl);
    logic [7:0] d;
    fifo_en = 1'b1; irq_en = 4'b0001; trig_sel = sel;
    for (int i = 0; i < lvl - 1; i++) push(8'(i));
    chk("R3", "irq one below level", irq, 0);
    push(8'hA5);
    chk("R3", "irq at level", irq, 1);
    chk("R3", "status at level", irq_status, 4'b0100);
    pop(d);
    chk("R4", "irq after dropping below", irq, 0);
    chk("R4", "status after dropping below", irq_status, 4'b0001);
    drain();
  endtask

  task automatic t_rx_disabled();
    fifo_en = 1'b1; irq_en = 4'b1110; trig_sel = 2'b00;
    push(8'h01); push(8'h02);
    chk("R5", "irq without receive enable", irq, 0);
    chk("R5", "status without receive enable", irq_status, 4'b0001);
    chk("R5", "ready still set", data_ready, 1);
    drain();
  endtask

  task automatic t_polled();
    logic [7:0] d;
    fifo_en = 1'b1; irq_en = 4'b0000; trig_sel = 2'b01;
    for (int i = 0; i < 5; i++) push(8'h40 + 8'(i));
    chk("R6", "irq in polled mode", irq, 0);
    chk("R6", "ready in polled mode", data_ready, 1);
    for (int i = 0; i < 5; i++) begin
      pop(d); chk("R6", "polled order", d, 8'h40 + 8'(i));
    end
    chk("R6", "ready after polled drain", data_ready, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    fifo_en = 1'b1; irq_en = 4'b0001; trig_sel = 2'b11;
    for (int i = 0; i < DEPTH; i++) push(8'(i));
    chk("R7", "no overrun at full", overrun, 0);
    chk("R3", "irq at full with level 14", irq, 1);
    push(8'hEE);
    chk("R7", "overrun on write to full", overrun, 1);
    pop(d);
    chk("R7", "first after overrun", d, 8'h00);
    chk("R7", "overrun cleared by read", overrun, 0);
    chk("R4", "irq at 15 with level 14", irq, 1);
    pop(d);
    chk("R4", "irq at 14 with level 14", irq, 1);
    pop(d);
    chk("R4", "irq at 13 with level 14", irq, 0);
    for (int i = 3; i < DEPTH; i++) begin
      pop(d); chk("R7", "kept entries in order", d, 8'(i));
    end
    chk("R7", "dropped char absent", data_ready, 0);
  endtask

  task automatic t_empty_read();
    logic [7:0] d;
    pop(d);
    chk("R11", "rd_data held on empty read", d, 8'h0F);
    chk("R11", "still empty", data_ready, 0);
    push(8'h5A);
    pop(d);
    chk("R11", "storage intact after empty read", d, 8'h5A);
  endtask

  task automatic t_single();
    logic [7:0] d;
    fifo_en = 1'b0; irq_en = 4'b0001; trig_sel = 2'b11;
    @(negedge clk);
    push(8'hC3);
    chk("R8", "irq follows ready", irq, 1);
    chk("R8", "status in single mode", irq_status, 4'b0100);
    push(8'h3C);
    chk("R8", "second write overruns", overrun, 1);
    pop(d);
    chk("R8", "held char", d, 8'hC3);
    chk("R8", "ready cleared", data_ready, 0);
    chk("R8", "irq cleared", irq, 0);
  endtask

  task automatic t_flush();
    fifo_en = 1'b1; irq_en = 4'b0001; trig_sel = 2'b00;
    @(negedge clk);
    push(8'h71); push(8'h72); push(8'h73);
    chk("R9", "irq before switch", irq, 1);
    fifo_en = 1'b0;
    @(negedge clk);
    chk("R9", "ready after switch", data_ready, 0);
    chk("R9", "irq after switch", irq, 0);
    fifo_en = 1'b1;
    @(negedge clk);
    chk("R9", "empty after switching back", data_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_trigger(2'b01, 4);
    t_trigger(2'b10, 8);
    t_trigger(2'b11, 14);
    t_rx_disabled();
    t_polled();
    t_overrun();
    t_empty_read();
    t_single();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule